// File: doc/BRIEF.md
# Chained Vector Register File

This block holds a bank of vector registers and streams their elements through two pipelined integer units, an adder/subtractor and a bitwise-logic unit. Each unit reads one element of each source and retires one result element per clock. A vector length register, sampled when an operation is accepted, sets how many leading elements the operation touches. A vector mask register steers the merge operation element by element. A scalar port fills and reads single elements, so the surrounding logic can load operands and inspect results.

When an accepted operation names, as a source, the register that the other unit is still producing, it does not wait for that vector to finish. It reads element i as soon as the producer has written element i, so the two units overlap almost completely. Issue stalls when the required unit is occupied, or when the destination is still being read or written by an operation in flight. Opcodes 6 and 7 are accepted and do nothing.

Each unit is run by a three-state sequencer. LS_IDLE goes to LS_STREAM when an operation starts. LS_STREAM goes to LS_DRAIN when the final source element is read. LS_DRAIN goes back to LS_IDLE when the final result is written. A per-register busy vector and a global idle flag show when results are complete.

Top module: `vrf_chain_top`

## Requirements
- R1: After reset, `idle` is 1, `reg_busy` is all zero, `iss_ready` is 1, and the vector length is 64.
- R2: A scalar write stores `sc_wdata` at element `sc_widx` of register `sc_wreg` unless that register is busy, in which case the write is ignored. `sc_rdata` shows element `sc_ridx` of register `sc_rreg` combinationally.
- R3: Opcode 0 (add) and opcode 1 (subtract, first source minus second) compute element-wise modulo 2^64. Element 0 of the destination changes at the fourth rising edge after the accepting edge.
- R4: Opcodes 2 (AND), 3 (OR) and 4 (XOR) compute element-wise. Element 0 of the destination changes at the third rising edge after the accepting edge.
- R5: Opcode 5 (merge) writes element i from the first source when mask bit i is 1, and from the second source when it is 0. The mask is loaded whole through `vm_we`/`vm_din`, where bit i belongs to element i.
- R6: An operation writes only elements 0 to VL-1 and leaves the others unchanged. VL is captured when the operation is accepted, so later VL writes do not affect it. A VL write of 0 or above 64 is ignored.
- R7: When an operation reads a register that the other unit is still writing, element i is consumed once the producer has written element i. The consumer's element 0 lands while the producer is still busy. A 64-element add chained into a logic operation finishes 68 cycles after the second issue.
- R8: An operation whose unit is already running is held (`iss_ready` low) until that unit finishes, and then executes correctly.
- R9: `iss_ready` is low when the destination is a source or the destination of an operation in flight. It stays high for an unrelated destination on a free unit.
- R10: An operation that reads a register whose producer has already completed reads it from element 0 and gives correct results.
- R11: While operations run, `reg_busy` flags every destination in flight and every source still being streamed, and `idle` is 0.
- R12: Opcodes 6 and 7 are accepted but change no register and leave `idle` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request |
| iss_op | input | 3 | Opcode |
| iss_dst | input | 3 | Destination register |
| iss_srca | input | 3 | First source register |
| iss_srcb | input | 3 | Second source register |
| iss_ready | output | 1 | Issue may be accepted this cycle |
| vl_we | input | 1 | Vector length write strobe |
| vl_din | input | 7 | New vector length (1 to 64) |
| vm_we | input | 1 | Mask write strobe |
| vm_din | input | 64 | New mask, bit i for element i |
| sc_we | input | 1 | Scalar element write strobe |
| sc_wreg | input | 3 | Scalar write register |
| sc_widx | input | 6 | Scalar write element |
| sc_wdata | input | 64 | Scalar write data |
| sc_rreg | input | 3 | Scalar read register |
| sc_ridx | input | 6 | Scalar read element |
| sc_rdata | output | 64 | Scalar read data |
| reg_busy | output | 8 | Per-register busy flags |
| idle | output | 1 | No operation in flight |

## Verification
A wrong written-element count in the producer shows up in a chained consumer. It either reads a stale element, which is visible in the destination through the scalar port after completion, or it stalls for good, which holds `idle` low. A sequencer stuck in the wrong state shows on `reg_busy` and `iss_ready` within one cycle of the accepting edge. A pipeline of the wrong depth moves the edge at which element 0 appears by one cycle. The bench probes that edge exactly, and it also reads element 0 of a chained consumer while its producer is still flagged busy.

// File: rtl/vrf_pkg.sv
package vrf_pkg;
    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_AND = 3'd2,
        OP_OR  = 3'd3,
        OP_XOR = 3'd4,
        OP_MRG = 3'd5,
        OP_RS6 = 3'd6,
        OP_RS7 = 3'd7
    } vop_t;

    typedef enum logic [1:0] {
        LS_IDLE   = 2'd0,
        LS_STREAM = 2'd1,
        LS_DRAIN  = 2'd2
    } lane_st_t;
endpackage

// File: rtl/vfu_lane.sv
module vfu_lane
    import vrf_pkg::*;
#(
    parameter int W      = 64,
    parameter int NELEM  = 64,
    parameter int RW     = 3,
    parameter int LAT    = 2,
    parameter bit IS_ADD = 1'b0,
    localparam int IW    = $clog2(NELEM),
    localparam int LW    = $clog2(NELEM + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  vop_t          op_i,
    input  logic [RW-1:0] dst_i,
    input  logic [RW-1:0] sa_i,
    input  logic [RW-1:0] sb_i,
    input  logic [LW-1:0] len_i,
    input  logic [W-1:0]  opa,
    input  logic [W-1:0]  opb,
    input  logic          mbit,
    input  logic          src_ok,
    output logic          active,
    output logic          streaming,
    output logic [RW-1:0] dst_o,
    output logic [RW-1:0] sa_o,
    output logic [RW-1:0] sb_o,
    output logic [IW-1:0] rd_idx,
    output logic          wr_en,
    output logic [IW-1:0] wr_idx,
    output logic [W-1:0]  wr_data,
    output logic [LW-1:0] wr_cnt
);
    lane_st_t       st_q, st_d;
    vop_t           op_q;
    logic [LW-1:0]  len_q;
    logic [W-1:0]   res;
    logic           fire, last_rd, last_wr;
    logic [LAT-1:0] pv;
    logic [IW-1:0]  pidx [LAT];
    logic [W-1:0]   pdat [LAT];

    assign fire    = (st_q == LS_STREAM) && src_ok;
    assign last_rd = (LW'(rd_idx) == len_q - LW'(1));
    assign last_wr = wr_en && (LW'(wr_idx) == len_q - LW'(1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= LS_IDLE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            LS_IDLE:   if (start)           st_d = LS_STREAM;
            LS_STREAM: if (fire && last_rd) st_d = LS_DRAIN;
            LS_DRAIN:  if (last_wr)         st_d = LS_IDLE;
            default:                        st_d = LS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        active    = (st_q != LS_IDLE);
        streaming = (st_q == LS_STREAM);
        wr_en     = pv[LAT-1];
        wr_idx    = pidx[LAT-1];
        wr_data   = pdat[LAT-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= OP_ADD;
            dst_o  <= '0;
            sa_o   <= '0;
            sb_o   <= '0;
            len_q  <= LW'(NELEM);
            rd_idx <= '0;
            wr_cnt <= '0;
        end else if (start) begin
            op_q   <= op_i;
            dst_o  <= dst_i;
            sa_o   <= sa_i;
            sb_o   <= sb_i;
            len_q  <= len_i;
            rd_idx <= '0;
            wr_cnt <= '0;
        end else begin
            if (fire)  rd_idx <= rd_idx + IW'(1);
            if (wr_en) wr_cnt <= wr_cnt + LW'(1);
        end
    end

    generate
        if (IS_ADD) begin : g_add
            always_comb res = (op_q == OP_SUB) ? (opa - opb) : (opa + opb);
        end else begin : g_logic
            always_comb begin
                unique case (op_q)
                    OP_AND:  res = opa & opb;
                    OP_OR:   res = opa | opb;
                    OP_XOR:  res = opa ^ opb;
                    default: res = mbit ? opa : opb;
                endcase
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) pv <= '0;
        else        pv <= {pv[LAT-2:0], fire};
    end

    always_ff @(posedge clk) begin
        pidx[0] <= rd_idx;
        pdat[0] <= res;
        for (int k = 1; k < LAT; k++) begin
            pidx[k] <= pidx[k-1];
            pdat[k] <= pdat[k-1];
        end
    end

    // R6
    wr_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (LW'(wr_idx) < len_q));
    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == LS_IDLE) |-> !wr_en);
    // R8
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (st_q == LS_IDLE));
endmodule

// File: rtl/vrf_chain_top.sv
module vrf_chain_top
    import vrf_pkg::*;
#(
    parameter int NREG    = 8,
    parameter int NELEM   = 64,
    parameter int W       = 64,
    parameter int ADD_LAT = 3,
    parameter int LOG_LAT = 2,
    localparam int RW     = $clog2(NREG),
    localparam int IW     = $clog2(NELEM),
    localparam int LW     = $clog2(NELEM + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             iss_valid,
    input  logic [2:0]       iss_op,
    input  logic [RW-1:0]    iss_dst,
    input  logic [RW-1:0]    iss_srca,
    input  logic [RW-1:0]    iss_srcb,
    output logic             iss_ready,
    input  logic             vl_we,
    input  logic [LW-1:0]    vl_din,
    input  logic             vm_we,
    input  logic [NELEM-1:0] vm_din,
    input  logic             sc_we,
    input  logic [RW-1:0]    sc_wreg,
    input  logic [IW-1:0]    sc_widx,
    input  logic [W-1:0]     sc_wdata,
    input  logic [RW-1:0]    sc_rreg,
    input  logic [IW-1:0]    sc_ridx,
    output logic [W-1:0]     sc_rdata,
    output logic [NREG-1:0]  reg_busy,
    output logic             idle
);
    localparam int NU = 2;

    logic [LW-1:0]    vl_q;
    logic [NELEM-1:0] vm_q;
    logic [W-1:0]     vmem [NREG][NELEM];

    vop_t          iop;
    logic          is_add, is_log;
    logic [NU-1:0] u_start, u_act, u_str, u_ok, u_wen, u_mbit;
    logic [RW-1:0] u_dst [NU];
    logic [RW-1:0] u_sa [NU];
    logic [RW-1:0] u_sb [NU];
    logic [IW-1:0] u_ridx [NU];
    logic [IW-1:0] u_widx [NU];
    logic [W-1:0]  u_wdat [NU];
    logic [W-1:0]  u_opa [NU];
    logic [W-1:0]  u_opb [NU];
    logic [LW-1:0] u_wcnt [NU];

    assign iop    = vop_t'(iss_op);
    assign is_add = (iop == OP_ADD) || (iop == OP_SUB);
    assign is_log = (iop == OP_AND) || (iop == OP_OR) || (iop == OP_XOR) || (iop == OP_MRG);

    always_comb begin
        if (is_add)      iss_ready = !u_act[0] && !reg_busy[iss_dst];
        else if (is_log) iss_ready = !u_act[1] && !reg_busy[iss_dst];
        else             iss_ready = 1'b1;
    end

    assign u_start[0] = iss_valid && iss_ready && is_add;
    assign u_start[1] = iss_valid && iss_ready && is_log;

    always_comb begin
        reg_busy = '0;
        for (int u = 0; u < NU; u++) begin
            if (u_act[u]) reg_busy[u_dst[u]] = 1'b1;
            if (u_str[u]) begin
                reg_busy[u_sa[u]] = 1'b1;
                reg_busy[u_sb[u]] = 1'b1;
            end
        end
    end

    assign idle     = ~|u_act;
    assign sc_rdata = vmem[sc_rreg][sc_ridx];

    generate
        for (genvar u = 0; u < NU; u++) begin : g_unit
            localparam int V = NU - 1 - u;
            logic ok_a, ok_b;

            assign u_opa[u]  = vmem[u_sa[u]][u_ridx[u]];
            assign u_opb[u]  = vmem[u_sb[u]][u_ridx[u]];
            assign u_mbit[u] = vm_q[u_ridx[u]];
            assign ok_a = (u_sa[u] == u_dst[u]) || !(u_act[V] && (u_dst[V] == u_sa[u]))
                          || (u_wcnt[V] > LW'(u_ridx[u]));
            assign ok_b = (u_sb[u] == u_dst[u]) || !(u_act[V] && (u_dst[V] == u_sb[u]))
                          || (u_wcnt[V] > LW'(u_ridx[u]));
            assign u_ok[u] = ok_a && ok_b;

            vfu_lane #(
                .W(W), .NELEM(NELEM), .RW(RW),
                .LAT((u == 0) ? ADD_LAT : LOG_LAT),
                .IS_ADD(u == 0)
            ) u_lane (
                .clk(clk), .rst_n(rst_n), .start(u_start[u]), .op_i(iop),
                .dst_i(iss_dst), .sa_i(iss_srca), .sb_i(iss_srcb), .len_i(vl_q),
                .opa(u_opa[u]), .opb(u_opb[u]), .mbit(u_mbit[u]), .src_ok(u_ok[u]),
                .active(u_act[u]), .streaming(u_str[u]), .dst_o(u_dst[u]),
                .sa_o(u_sa[u]), .sb_o(u_sb[u]), .rd_idx(u_ridx[u]),
                .wr_en(u_wen[u]), .wr_idx(u_widx[u]), .wr_data(u_wdat[u]),
                .wr_cnt(u_wcnt[u])
            );

            // R7
            chain_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (u_str[u] && u_ok[u] && u_act[V] && (u_dst[V] == u_sa[u]) && (u_sa[u] != u_dst[u]))
                |-> (u_wcnt[V] > LW'(u_ridx[u])));
        end
    endgenerate

    always_ff @(posedge clk) begin
        for (int u = 0; u < NU; u++)
            if (u_wen[u]) vmem[u_dst[u]][u_widx[u]] <= u_wdat[u];
        if (sc_we && !reg_busy[sc_wreg]) vmem[sc_wreg][sc_widx] <= sc_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vl_q <= LW'(NELEM);
            vm_q <= '0;
        end else begin
            if (vl_we && (vl_din != '0) && (vl_din <= LW'(NELEM))) vl_q <= vl_din;
            if (vm_we) vm_q <= vm_din;
        end
    end

    // R9
    wr_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(u_wen[0] && u_wen[1] && (u_dst[0] == u_dst[1])));
    // R6
    vl_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vl_q != '0) && (vl_q <= LW'(NELEM)));
    // R11
    idle_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (reg_busy == '0));
    // R12
    start_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(u_act[0]) |-> $past(iss_valid));
endmodule

// File: tb/vrf_chain_top_tb.sv
`timescale 1ns/1ps
module vrf_chain_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        iss_valid = 1'b0;
    logic [2:0]  iss_op = '0, iss_dst = '0, iss_srca = '0, iss_srcb = '0;
    logic        iss_ready;
    logic        vl_we = 1'b0;
    logic [6:0]  vl_din = '0;
    logic        vm_we = 1'b0;
    logic [63:0] vm_din = '0;
    logic        sc_we = 1'b0;
    logic [2:0]  sc_wreg = '0, sc_rreg = '0;
    logic [5:0]  sc_widx = '0, sc_ridx = '0;
    logic [63:0] sc_wdata = '0, sc_rdata;
    logic [7:0]  reg_busy;
    logic        idle;

    int errs = 0;
    int chks = 0;
    logic [63:0] mdl [8][64];
    logic [63:0] mmask = '0;

    typedef struct packed {
        logic [2:0] op;
        logic [2:0] d;
        logic [2:0] a;
        logic [2:0] b;
        logic [6:0] vl;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t TBL [NV] = '{
        '{3'd0, 3'd2, 3'd0, 3'd1, 7'd64},
        '{3'd1, 3'd3, 3'd1, 3'd0, 7'd64},
        '{3'd2, 3'd4, 3'd0, 3'd5, 7'd64},
        '{3'd3, 3'd5, 3'd2, 3'd6, 7'd17},
        '{3'd4, 3'd6, 3'd3, 3'd7, 7'd1},
        '{3'd5, 3'd7, 3'd0, 3'd1, 7'd64},
        '{3'd0, 3'd0, 3'd0, 3'd0, 7'd33},
        '{3'd5, 3'd1, 3'd2, 3'd3, 7'd40}
    };

    vrf_chain_top u_dut (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_op(iss_op),
        .iss_dst(iss_dst), .iss_srca(iss_srca), .iss_srcb(iss_srcb),
        .iss_ready(iss_ready), .vl_we(vl_we), .vl_din(vl_din), .vm_we(vm_we),
        .vm_din(vm_din), .sc_we(sc_we), .sc_wreg(sc_wreg), .sc_widx(sc_widx),
        .sc_wdata(sc_wdata), .sc_rreg(sc_rreg), .sc_ridx(sc_ridx),
        .sc_rdata(sc_rdata), .reg_busy(reg_busy), .idle(idle)
    );

    always #2.5 clk = ~clk;

    initial begin
        #(200000 * 5);
        errs++;
        chks++;
        $display("FAIL watchdog (all requirements): got hang expected completion");
        $display("Result: errors=%0d of %0d checks", errs, chks);
        $finish;
    end

    function automatic logic [63:0] pat(int r, int i);
        return (64'h9E37_79B9_7F4A_7C15 * 64'(r * 64 + i + 1)) ^ (64'(i) << 40);
    endfunction

    function automatic string opreq(int op);
        if (op <= 1) return "R3";
        if (op <= 4) return "R4";
        return "R5";
    endfunction

    task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
        chks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic rd(int r, int i, output logic [63:0] v);
        sc_rreg = 3'(r);
        sc_ridx = 6'(i);
        #1;
        v = sc_rdata;
    endtask

    task automatic check_reg(int r, string tag);
        int bad = -1;
        logic [63:0] got, badv;
        badv = '0;
        for (int i = 0; i < 64; i++) begin
            rd(r, i, got);
            if (got !== mdl[r][i] && bad < 0) begin
                bad = i;
                badv = got;
            end
        end
        if (bad < 0) chk(1'b1, tag, "register", '0, '0);
        else chk(1'b0, tag, $sformatf("reg %0d elem %0d", r, bad), badv, mdl[r][bad]);
    endtask

    task automatic model_op(int op, int d, int a, int b, int vl);
        logic [63:0] x, y, z;
        for (int i = 0; i < vl; i++) begin
            x = mdl[a][i];
            y = mdl[b][i];
            case (op)
                0: z = x + y;
                1: z = x - y;
                2: z = x & y;
                3: z = x | y;
                4: z = x ^ y;
                5: z = mmask[i] ? x : y;
                default: z = mdl[d][i];
            endcase
            mdl[d][i] = z;
        end
    endtask

    task automatic issue(int op, int d, int a, int b);
        @(negedge clk);
        iss_op = 3'(op); iss_dst = 3'(d); iss_srca = 3'(a); iss_srcb = 3'(b);
        iss_valid = 1'b1;
        #1;
        while (!iss_ready) @(negedge clk);
        @(negedge clk);
        iss_valid = 1'b0;
    endtask

    task automatic vl_write(int v);
        @(negedge clk);
        vl_we = 1'b1;
        vl_din = 7'(v);
        @(negedge clk);
        vl_we = 1'b0;
    endtask

    task automatic sc_write(int r, int i, logic [63:0] v);
        @(negedge clk);
        sc_we = 1'b1; sc_wreg = 3'(r); sc_widx = 6'(i); sc_wdata = v;
        @(negedge clk);
        sc_we = 1'b0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (!idle && n < 400) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        int n, vl_cur;
        logic [63:0] v, oldv;
        vl_cur = 64;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(idle == 1'b1, "R1", "idle", 64'(idle), 64'd1);
        chk(reg_busy == 8'h00, "R1", "reg_busy", 64'(reg_busy), 64'd0);
        chk(iss_ready == 1'b1, "R1", "iss_ready", 64'(iss_ready), 64'd1);

        // R2 fill through the scalar port
        for (int r = 0; r < 8; r++) begin
            for (int i = 0; i < 64; i++) begin
                @(negedge clk);
                sc_we = 1'b1; sc_wreg = 3'(r); sc_widx = 6'(i); sc_wdata = pat(r, i);
                mdl[r][i] = pat(r, i);
            end
        end
        @(negedge clk);
        sc_we = 1'b0;
        check_reg(7, "R2");
        check_reg(0, "R2");

        // R5 mask load
        @(negedge clk);
        vm_we = 1'b1;
        vm_din = 64'hF0F0_3C3C_A5A5_0FF1;
        mmask = vm_din;
        @(negedge clk);
        vm_we = 1'b0;

        // table of operations (R3 R4 R5; short lengths also cover R6)
        for (int k = 0; k < NV; k++) begin
            if (int'(TBL[k].vl) != vl_cur) begin
                vl_write(int'(TBL[k].vl));
                vl_cur = int'(TBL[k].vl);
            end
            issue(int'(TBL[k].op), int'(TBL[k].d), int'(TBL[k].a), int'(TBL[k].b));
            wait_idle(n);
            model_op(int'(TBL[k].op), int'(TBL[k].d), int'(TBL[k].a), int'(TBL[k].b), vl_cur);
            check_reg(int'(TBL[k].d), opreq(int'(TBL[k].op)));
        end

        vl_write(64);
        vl_cur = 64;

        // R3 adder latency: element 0 changes at the fourth edge
        oldv = mdl[1][0];
        issue(0, 1, 2, 3);
        model_op(0, 1, 2, 3, 64);
        repeat (3) @(negedge clk);
        rd(1, 0, v);
        chk(v === oldv, "R3", "elem0 before fourth edge", v, oldv);
        @(negedge clk);
        rd(1, 0, v);
        chk(v === mdl[1][0], "R3", "elem0 after fourth edge", v, mdl[1][0]);
        wait_idle(n);
        check_reg(1, "R3");

        // R4 logic latency: element 0 changes at the third edge
        oldv = mdl[4][0];
        issue(4, 4, 0, 1);
        model_op(4, 4, 0, 1, 64);
        repeat (2) @(negedge clk);
        rd(4, 0, v);
        chk(v === oldv, "R4", "elem0 before third edge", v, oldv);
        @(negedge clk);
        rd(4, 0, v);
        chk(v === mdl[4][0], "R4", "elem0 after third edge", v, mdl[4][0]);
        wait_idle(n);

        // R7 chaining add -> xor, R11 busy flags
        issue(0, 2, 0, 1);
        issue(4, 3, 2, 4);
        model_op(0, 2, 0, 1, 64);
        model_op(4, 3, 2, 4, 64);
        chk(reg_busy == 8'h1F, "R11", "reg_busy while chained", 64'(reg_busy), 64'h1F);
        chk(idle == 1'b0, "R11", "idle while running", 64'(idle), 64'd0);
        repeat (5) @(negedge clk);
        rd(3, 0, v);
        chk(v === mdl[3][0], "R7", "consumer elem0 during producer", v, mdl[3][0]);
        chk(reg_busy[2] == 1'b1, "R7", "producer still busy", 64'(reg_busy[2]), 64'd1);
        wait_idle(n);
        chk(n == 63, "R7", "cycles to idle after chained issue", 64'(n + 5), 64'd68);
        check_reg(2, "R7");
        check_reg(3, "R7");

        // R8 structural stall on the adder
        vl_write(16);
        vl_cur = 16;
        issue(0, 5, 0, 1);
        @(negedge clk);
        iss_op = 3'd0; iss_dst = 3'd6; iss_srca = 3'd2; iss_srcb = 3'd3;
        iss_valid = 1'b1;
        #1;
        chk(iss_ready == 1'b0, "R8", "ready while adder busy", 64'(iss_ready), 64'd0);
        while (!iss_ready) @(negedge clk);
        @(negedge clk);
        iss_valid = 1'b0;
        wait_idle(n);
        model_op(0, 5, 0, 1, 16);
        model_op(0, 6, 2, 3, 16);
        check_reg(5, "R8");
        check_reg(6, "R8");

        // R9 hazard stalls, R2 write to busy register ignored
        vl_write(64);
        vl_cur = 64;
        issue(0, 5, 6, 7);
        model_op(0, 5, 6, 7, 64);
        iss_op = 3'd2; iss_srca = 3'd0; iss_srcb = 3'd1;
        iss_dst = 3'd6;
        #1;
        chk(iss_ready == 1'b0, "R9", "dst is in-flight source", 64'(iss_ready), 64'd0);
        iss_dst = 3'd5;
        #1;
        chk(iss_ready == 1'b0, "R9", "dst is in-flight dst", 64'(iss_ready), 64'd0);
        iss_dst = 3'd4;
        #1;
        chk(iss_ready == 1'b1, "R9", "unrelated dst", 64'(iss_ready), 64'd1);
        sc_write(6, 63, ~mdl[6][63]);
        wait_idle(n);
        check_reg(6, "R2");
        check_reg(5, "R9");

        // R6 length captured at issue; illegal lengths ignored
        vl_write(8);
        issue(0, 1, 2, 3);
        vl_write(64);
        wait_idle(n);
        model_op(0, 1, 2, 3, 8);
        check_reg(1, "R6");
        vl_write(0);
        vl_write(65);
        issue(4, 4, 0, 1);
        wait_idle(n);
        model_op(4, 4, 0, 1, 64);
        check_reg(4, "R6");

        // R10 read of a completed register
        issue(1, 0, 1, 4);
        wait_idle(n);
        model_op(1, 0, 1, 4, 64);
        check_reg(0, "R10");

        // R12 reserved opcode
        @(negedge clk);
        iss_op = 3'd6; iss_dst = 3'd0; iss_srca = 3'd1; iss_srcb = 3'd2;
        iss_valid = 1'b1;
        #1;
        chk(iss_ready == 1'b1, "R12", "ready for reserved", 64'(iss_ready), 64'd1);
        @(negedge clk);
        iss_valid = 1'b0;
        repeat (6) @(negedge clk);
        chk(idle == 1'b1, "R12", "idle after reserved", 64'(idle), 64'd1);
        check_reg(0, "R12");

        $display("Result: errors=%0d of %0d checks", errs, chks);
        $finish;
    end
endmodule